// File: doc/BRIEF.md
# Sampling Converter Control and Serial Readout

This block is the digital side of a 12-bit single-channel successive-approximation converter. A parallel sample word stands in for the analog front end. An active-low convert-start input freezes that word and starts a conversion. The conversion is timed by the block's own internal clock and not by the serial clock. The result is then shifted out MSB first, in straight binary, on a serial data line that has its own output-enable.

There is no command register. The levels of convert-start and chip select at the end of a conversion decide two things: whether the block stays powered or drops into power-down, and which readout framing the next read uses. A chip select released part-way through a read arms a software reset, which acts at the end of the following conversion. Serial clock, chip select and convert-start are each brought into the internal clock through a two-flop synchroniser, and their edges are found there. The internal clock is expected to run at least four times as fast as the serial clock.

Top module: `adc_ctl_top`

## Requirements
- R1: After a detected convert-start falling edge in the ready state, `busy` is high for exactly CONV_CYC internal clock cycles. The word on `sample_i` at that edge is the one converted, even if `sample_i` changes during the conversion.
- R2: A convert-start falling edge that arrives during a conversion is ignored. The conversion keeps its length and keeps its first sample.
- R3: At end of conversion, a high convert-start leaves the block in normal mode (`pdown` = 0), and a low convert-start puts it into power-down (`pdown` = 1).
- R4: In power-down, a convert-start rising edge raises `waking` for exactly WAKE_CYC cycles and then returns the block to ready. A convert-start falling edge during that window starts no conversion.
- R5: The serial port works in power-down, and a plain read there returns the last conversion result.
- R6: If chip select is low at end of conversion, busy-indicator framing is used (`busy_frame` = 1). After end of conversion, `sdo_oe` = 1 and `sdo` = 0. Serial-clock falling edges 1 to 12 present bits 11 down to 0, and the 13th falling edge releases the line.
- R7: If chip select is high at end of conversion, plain framing is used (`busy_frame` = 0). A chip-select falling edge enables the line with bit 11. Serial-clock falling edges 1 to 11 present bits 10 down to 0, and the 12th falling edge releases the line.
- R8: A chip-select rising edge drives `sdo_oe` low at any point of a read.
- R9: A chip-select rising edge after 2 to 7 serial-clock falling edges of a read, counted from the frame start, arms a reset. After 1, 8 or more falling edges it arms nothing. An armed reset acts at the next end of conversion: the stored result becomes 0 and the reset is used up.
- R10: After power-on reset, `no_swrst` = 1. It goes to 0 when an armed reset executes, and it never returns to 1.
- R11: After power-on reset, `sdo_oe`, `busy`, `pdown` and `waking` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low power-on reset |
| convst_n | input | 1 | Active-low convert-start; its level at end of conversion selects the power mode |
| cs_n | input | 1 | Active-low chip select; frames reads and selects the framing |
| sclk | input | 1 | Serial clock; data change on its falling edge |
| sample_i | input | DW | Stand-in for the analog input |
| sdo | output | 1 | Serial data, MSB first |
| sdo_oe | output | 1 | Enable of the serial data driver |
| busy | output | 1 | Conversion in progress |
| pdown | output | 1 | Block is in power-down |
| waking | output | 1 | Power-up wait in progress |
| busy_frame | output | 1 | Framing chosen at the last end of conversion (1 = busy-indicator) |
| no_swrst | output | 1 | No software reset has executed since power-on |

## Verification
Conversions are run with three convert-start shapes: released early, held low through the end of conversion, and pulsed again mid-conversion. These separate the normal mode, the power-down mode and the ignored retrigger, and the sample input changes during each conversion to show that the word was frozen. Reads are made with chip select low at end of conversion and with chip select high, so that the one-edge shift between the two framings is checked bit by bit. Chip select is released after 1, 2, 8, 12 and 13 falling edges to probe both sides of the reset-arming window, and a read after the next conversion shows whether a reset executed.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
    // Power / activity state of the conversion controller
    typedef enum logic [1:0] {
        PW_READY = 2'd0,
        PW_CONV  = 2'd1,
        PW_DOWN  = 2'd2,
        PW_WAKE  = 2'd3
    } pwr_st_e;

    // Falling-edge window of a read in which a chip-select release arms a reset
    localparam int ARM_FIRST = 2;
    localparam int ARM_LAST  = 7;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    // chain_q[0] first flop, chain_q[STAGES-1] synchronised, chain_q[STAGES] one cycle older
    logic [STAGES:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctl_pkg::*;
#(
    parameter int DW       = 12,
    parameter int CONV_CYC = 65,
    parameter int WAKE_CYC = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cv_lvl,
    input  logic          cv_rise,
    input  logic          cv_fall,
    input  logic [DW-1:0] sample_i,
    input  logic          arm_i,
    output logic          eoc_o,
    output logic [DW-1:0] eoc_word_o,
    output logic [DW-1:0] result_o,
    output logic          busy_o,
    output logic          pdown_o,
    output logic          wake_o,
    output logic          no_swrst_o
);
    localparam int MAXC = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        pwr_st_e       st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] smp;
        logic [DW-1:0] res;
        logic          noswrst;
    } conv_t;

    conv_t d, q;
    logic  eoc;

    always_comb begin
        d   = q;
        eoc = 1'b0;
        unique case (q.st)
            PW_READY: begin
                if (cv_fall) begin
                    d.st  = PW_CONV;
                    d.cnt = CW'(CONV_CYC - 1);
                    d.smp = sample_i;
                end
            end
            PW_CONV: begin
                if (q.cnt == '0) begin
                    eoc   = 1'b1;
                    d.res = arm_i ? '0 : q.smp;
                    if (arm_i) d.noswrst = 1'b0;
                    d.st  = cv_lvl ? PW_READY : PW_DOWN;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            PW_DOWN: begin
                if (cv_rise) begin
                    d.st  = PW_WAKE;
                    d.cnt = CW'(WAKE_CYC - 1);
                end
            end
            PW_WAKE: begin
                if (q.cnt == '0) d.st  = PW_READY;
                else             d.cnt = q.cnt - CW'(1);
            end
            default: d.st = PW_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= PW_READY;
            q.cnt     <= '0;
            q.smp     <= '0;
            q.res     <= '0;
            q.noswrst <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign eoc_o      = eoc;
    assign eoc_word_o = arm_i ? '0 : q.smp;
    assign result_o   = q.res;
    assign busy_o     = (q.st == PW_CONV);
    assign pdown_o    = (q.st == PW_DOWN);
    assign wake_o     = (q.st == PW_WAKE);
    assign no_swrst_o = q.noswrst;

    // R1: the frozen sample does not move while converting
    a_r1_sample_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PW_CONV) |=> $stable(q.smp));

    // R2: a new start edge mid-conversion neither restarts nor stalls the count
    a_r2_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PW_CONV && q.cnt != '0 && cv_fall) |=>
            (q.st == PW_CONV && q.cnt == $past(q.cnt) - CW'(1)));

    // R3: low convert-start at end of conversion lands in power-down
    a_r3_low_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !cv_lvl) |=> (q.st == PW_DOWN));

    // R4: no conversion can begin straight out of the power-up wait
    a_r4_wake_no_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PW_WAKE) |=> (q.st != PW_CONV));

    // R10: the no-reset-yet flag never comes back
    a_r10_flag_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(q.noswrst));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_ctl_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          cs_rise,
    input  logic          cs_fall,
    input  logic          sck_fall,
    input  logic          eoc_i,
    input  logic [DW-1:0] eoc_word_i,
    input  logic [DW-1:0] rdata_i,
    output logic          sdo_o,
    output logic          sdo_oe_o,
    output logic          bframe_o,
    output logic          arm_o
);
    localparam int FCW = $clog2(DW + 2);

    typedef struct packed {
        logic [DW:0]    sh;
        logic           oe;
        logic           act;
        logic [FCW-1:0] nf;
        logic [FCW-1:0] lim;
        logic           bframe;
        logic           arm;
    } ser_t;

    ser_t d, q;

    always_comb begin
        d = q;
        if (eoc_i) d.arm = 1'b0;   // armed reset is consumed by this end of conversion
        if (cs_rise) begin
            d.oe  = 1'b0;
            d.act = 1'b0;
            if (q.act && q.nf >= FCW'(ARM_FIRST) && q.nf <= FCW'(ARM_LAST))
                d.arm = 1'b1;
        end else if (eoc_i) begin
            d.bframe = !cs_lvl;
            if (!cs_lvl) begin
                d.sh  = {1'b0, eoc_word_i};
                d.oe  = 1'b1;
                d.act = 1'b1;
                d.nf  = '0;
                d.lim = FCW'(DW + 1);
            end
        end else if (cs_fall) begin
            d.sh  = {rdata_i, 1'b0};
            d.oe  = 1'b1;
            d.act = 1'b1;
            d.nf  = '0;
            d.lim = FCW'(DW);
        end else if (sck_fall && q.act && q.nf < q.lim) begin
            d.nf = q.nf + FCW'(1);
            d.sh = {q.sh[DW-1:0], 1'b0};
            if (q.nf + FCW'(1) == q.lim) d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh     <= '0;
            q.oe     <= 1'b0;
            q.act    <= 1'b0;
            q.nf     <= '0;
            q.lim    <= '0;
            q.bframe <= 1'b0;
            q.arm    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sdo_o    = q.sh[DW];
    assign sdo_oe_o = q.oe;
    assign bframe_o = q.bframe;
    assign arm_o    = q.arm;

    // R8: releasing chip select always turns the driver off
    a_r8_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !q.oe);

    // R6: busy-indicator framing leads with a driven low level
    a_r6_lead_low: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_i && !cs_lvl) |=> (q.oe && !q.sh[DW]));

    // R7: a plain read shows the MSB as soon as chip select falls
    a_r7_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !eoc_i) |=> (q.oe && q.sh[DW] == $past(rdata_i[DW-1])));
endmodule

// File: rtl/adc_ctl_top.sv
module adc_ctl_top #(
    parameter int DW       = 12,
    parameter int CONV_CYC = 65,
    parameter int WAKE_CYC = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          convst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic [DW-1:0] sample_i,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          busy,
    output logic          pdown,
    output logic          waking,
    output logic          busy_frame,
    output logic          no_swrst
);
    // bit 0 convst_n, bit 1 cs_n, bit 2 sclk
    logic [2:0]    s_lvl, s_prev;
    logic          cv_rise, cv_fall, cs_rise, cs_fall, sck_fall;
    logic          eoc, arm;
    logic [DW-1:0] eoc_word, result;

    adc_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk, cs_n, convst_n}),
        .lvl_o   (s_lvl),
        .prev_o  (s_prev)
    );

    assign cv_rise  =  s_lvl[0] & ~s_prev[0];
    assign cv_fall  = ~s_lvl[0] &  s_prev[0];
    assign cs_rise  =  s_lvl[1] & ~s_prev[1];
    assign cs_fall  = ~s_lvl[1] &  s_prev[1];
    assign sck_fall = ~s_lvl[2] &  s_prev[2];

    adc_conv_ctrl #(.DW(DW), .CONV_CYC(CONV_CYC), .WAKE_CYC(WAKE_CYC)) i_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .cv_lvl     (s_lvl[0]),
        .cv_rise    (cv_rise),
        .cv_fall    (cv_fall),
        .sample_i   (sample_i),
        .arm_i      (arm),
        .eoc_o      (eoc),
        .eoc_word_o (eoc_word),
        .result_o   (result),
        .busy_o     (busy),
        .pdown_o    (pdown),
        .wake_o     (waking),
        .no_swrst_o (no_swrst)
    );

    adc_serial_port #(.DW(DW)) i_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_lvl     (s_lvl[1]),
        .cs_rise    (cs_rise),
        .cs_fall    (cs_fall),
        .sck_fall   (sck_fall),
        .eoc_i      (eoc),
        .eoc_word_i (eoc_word),
        .rdata_i    (result),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe),
        .bframe_o   (busy_frame),
        .arm_o      (arm)
    );
endmodule

// File: tb/test_adc_ctl_top.sv
module test_adc_ctl_top;
    localparam int DW   = 12;
    localparam int CONV = 65;
    localparam int WAKE = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          convst_n = 1'b1;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic          sdo, sdo_oe, busy, pdown, waking, busy_frame, no_swrst;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_ctl_top #(.DW(DW), .CONV_CYC(CONV), .WAKE_CYC(WAKE)) i_adc_ctl_top (
        .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .cs_n(cs_n), .sclk(sclk),
        .sample_i(sample_i), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .pdown(pdown),
        .waking(waking), .busy_frame(busy_frame), .no_swrst(no_swrst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // mode 0: release early, 1: hold low through end, 2: extra pulse mid-conversion
    task automatic do_conv(input logic [DW-1:0] w, input int mode);
        int cnt = 0;
        sample_i = w;
        convst_n = 1'b0;
        for (int i = 0; i < CONV + 30; i++) begin
            @(negedge clk);
            if (i == 10) sample_i = ~w;
            if (i == 5 && mode != 1) convst_n = 1'b1;
            if (mode == 2 && i == 20) convst_n = 1'b0;
            if (mode == 2 && i == 25) convst_n = 1'b1;
            if (busy) cnt++;
        end
        chk(cnt == CONV, (mode == 2) ? "R2 length" : "R1 busy length", cnt, CONV);
        chk(pdown == (mode == 1), "R3 mode at end", int'(pdown), int'(mode == 1));
    endtask

    task automatic sck_pulse();
        sclk = 1'b1; wait_clk(4);
        sclk = 1'b0; wait_clk(5);
    endtask

    // bmode: busy-indicator frame already open; nfall: serial falls before cs release
    task automatic read_bits(input bit bmode, input logic [DW-1:0] exp, input int nfall);
        int b;
        if (!bmode) begin
            cs_n = 1'b0; wait_clk(5);
            chk(sdo_oe && sdo == exp[DW-1], "R7 lead bit", int'({sdo_oe, sdo}), int'({1'b1, exp[DW-1]}));
        end else begin
            chk(sdo_oe && !sdo, "R6 lead low", int'({sdo_oe, sdo}), 2);
        end
        for (int k = 1; k <= nfall; k++) begin
            sck_pulse();
            b = bmode ? DW - k : DW - 1 - k;
            if (b >= 0)
                chk(sdo_oe && sdo == exp[b], bmode ? "R6 data bit" : "R7 data bit",
                    int'({sdo_oe, sdo}), int'({1'b1, exp[b]}));
            else if (b == -1)
                chk(!sdo_oe, bmode ? "R6 release" : "R7 release", int'(sdo_oe), 0);
        end
        cs_n = 1'b1; wait_clk(5);
        chk(!sdo_oe, "R8 cs release", int'(sdo_oe), 0);
    endtask

    task automatic t_reset();
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        chk({sdo_oe, busy, pdown, waking} == 4'b0, "R11 reset outputs",
            int'({sdo_oe, busy, pdown, waking}), 0);
        chk(no_swrst == 1'b1, "R10 flag after reset", int'(no_swrst), 1);
    endtask

    task automatic t_plain();
        do_conv(12'hA5C, 0);
        chk(busy_frame == 1'b0, "R7 framing flag", int'(busy_frame), 0);
        read_bits(1'b0, 12'hA5C, 12);
    endtask

    task automatic t_retrigger();
        do_conv(12'h3C3, 2);
        read_bits(1'b0, 12'h3C3, 12);
    endtask

    task automatic t_busy_frame();
        cs_n = 1'b0; wait_clk(6);
        do_conv(12'h5A6, 0);
        chk(busy_frame == 1'b1, "R6 framing flag", int'(busy_frame), 1);
        read_bits(1'b1, 12'h5A6, 13);
    endtask

    task automatic t_no_arm();
        do_conv(12'h2B4, 0);
        read_bits(1'b0, 12'h2B4, 1);   // 1 fall: outside window
        read_bits(1'b0, 12'h2B4, 8);   // 8 falls: outside window
        do_conv(12'h111, 0);
        read_bits(1'b0, 12'h111, 12);
        chk(no_swrst == 1'b1, "R9 no arm outside window", int'(no_swrst), 1);
    endtask

    task automatic t_power_down();
        int wc = 0;
        int bc = 0;
        do_conv(12'h7E1, 1);
        chk(pdown == 1'b1, "R3 power-down", int'(pdown), 1);
        read_bits(1'b0, 12'h7E1, 12);  // R5 read while powered down
        convst_n = 1'b1;
        for (int i = 0; i < WAKE + 40; i++) begin
            @(negedge clk);
            if (i == 20) convst_n = 1'b0;
            if (i == 30) convst_n = 1'b1;
            if (waking) wc++;
            if (busy) bc++;
        end
        chk(wc == WAKE, "R4 wake length", wc, WAKE);
        chk(bc == 0, "R4 fall during wake ignored", bc, 0);
        chk(!pdown && !waking, "R4 back to ready", int'({pdown, waking}), 0);
        do_conv(12'h0F0, 0);
        read_bits(1'b0, 12'h0F0, 12);
    endtask

    task automatic t_swrst();
        do_conv(12'h999, 0);
        read_bits(1'b0, 12'h999, 2);   // 2 falls: arms
        chk(no_swrst == 1'b1, "R9 armed not yet run", int'(no_swrst), 1);
        do_conv(12'hFFF, 0);
        read_bits(1'b0, 12'h000, 12);
        chk(no_swrst == 1'b0, "R10 flag cleared", int'(no_swrst), 0);
        do_conv(12'h123, 0);
        read_bits(1'b0, 12'h123, 12);
        chk(no_swrst == 1'b0, "R10 flag stays clear", int'(no_swrst), 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_retrigger();
        t_busy_frame();
        t_no_arm();
        t_power_down();
        t_swrst();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            report();
        end
    end
endmodule